// File: doc/BRIEF.md
# Asynchronous Byte-Lane Bus Master

This block runs the external bus cycles of a processor with a 16-bit data path and a 24-bit byte address. A core hands it one request at a time. Each request carries an address, a size (byte, word or long), a direction, user/supervisor and program/data flags, an interrupt-acknowledge flag and write data. The block runs a handshaken cycle on the bus pins. It sequences the function code, the direction, the address, the address strobe and the two byte-lane strobes. It then waits for a slave to acknowledge, and it returns to idle.

Address bit 0 never reaches the pins. It chooses the byte lane instead: the upper strobe covers data bits 15..8 (even bytes) and the lower strobe covers bits 7..0 (odd bytes). Data is big-endian. A long request runs as two word cycles, and the more significant half goes to the lower address first. When the transfer ends, a single-cycle done pulse appears on the response port with the read data or an error flag. A word or long request at an odd address is refused without a bus cycle. A bus-error input ends a cycle early with an error.

Top module: `abus_master`

## Requirements
- R1: After reset, and whenever no transfer is in progress, the address strobe and both data strobes are high (inactive), direction is high (read), the write-data enable is low, and the done pulse is low.
- R2: The address pins carry byte-address bits 23..1. A byte access at an even address asserts only the upper strobe (data bits 15..8). A byte access at an odd address asserts only the lower strobe (bits 7..0). A word access asserts both. No data strobe is low while the address strobe is high.
- R3: While the address strobe is low, the function code (bit 2..0) is 001 for user data, 010 for user program, 101 for supervisor data, 110 for supervisor program and 111 for interrupt acknowledge, which overrides the other flags.
- R4: A cycle holds its strobes and stays in its wait state until data-acknowledge (active low) is sampled low. With an acknowledge on the first possible sample, done appears 8 cycles after the request is sampled for a byte or word. Each extra cycle without acknowledge adds one cycle to that latency.
- R5: In a write, the data bus is driven, with the data enable high, before the data strobes fall. A byte write copies the byte onto both lanes, so only the strobed lane is written.
- R6: Storage is big-endian. A word puts bits 15..8 at the even address and bits 7..0 at the next one. A long (size code 2) runs two word cycles: bits 31..16 at the request address, then bits 15..0 at address+2. A long completes in 15 cycles with no wait states, and its read data returns as {first word, second word}.
- R7: A word (size code 1) or long request at an odd address produces done with error in the cycle after it is sampled. No address strobe is asserted and memory is unchanged.
- R8: Bus error (active low), sampled in the wait state, takes priority over acknowledge and ends the cycle with the error flag set and zero read data. Done appears 7 cycles after the request is sampled. A long request is abandoned after its first word, and nothing is written.
- R9: A request presented while a transfer is in progress is ignored: it produces no bus cycle, no done pulse and no memory change.
- R10: A byte read (size code 0) returns the selected lane in read-data bits 7..0, with the upper bits zero. A word read returns the bus word in bits 15..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present; sampled only while idle |
| req_addr_i | input | AW | Byte address |
| req_size_i | input | 2 | 0 byte, 1 word, 2 long |
| req_write_i | input | 1 | 1 write, 0 read |
| req_super_i | input | 1 | Supervisor access |
| req_prog_i | input | 1 | Program (not data) access |
| req_iack_i | input | 1 | Interrupt-acknowledge cycle |
| req_wdata_i | input | 2*DW | Write data, right aligned |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_err_o | output | 1 | Completion with error (valid with done) |
| rsp_rdata_o | output | 2*DW | Read data, right aligned |
| bus_addr_o | output | AW-1 | Address bits AW-1..1 |
| bus_as_no | output | 1 | Address strobe, active low |
| bus_uds_no | output | 1 | Upper data strobe, active low |
| bus_lds_no | output | 1 | Lower data strobe, active low |
| bus_rw_o | output | 1 | 1 read, 0 write |
| bus_fc_o | output | 3 | Function code |
| bus_data_o | output | DW | Write data to the bus |
| bus_data_oe_o | output | 1 | Enable for the data bus drivers |
| bus_data_i | input | DW | Read data from the bus |
| bus_dtack_ni | input | 1 | Data acknowledge, active low |
| bus_berr_ni | input | 1 | Bus error, active low |

## Verification
The bench builds the block with its default widths: 24 address bits and a 16-bit data path. With these widths the full 23-bit pin address can be checked using an address near the top of the space, both byte lanes are in play, and a long splits into exactly two word cycles. A slave model with a configurable wait count and an error mode tests the wait states, early bus-error ends and the abandonment of a long request. Latency, cycle count, function code and address are compared per transfer.

// File: rtl/abm_pkg.sv
package abm_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_LONG = 2'd2, SZ_RSVD = 2'd3} xfer_size_e;
  typedef enum logic [2:0] {PH_IDLE, PH_S0, PH_S1, PH_S2, PH_S3, PH_WAIT, PH_LATCH, PH_END} phase_e;
endpackage

// File: rtl/abm_fc_enc.sv
module abm_fc_enc (
  input  logic       super_i,
  input  logic       prog_i,
  input  logic       iack_i,
  output logic [2:0] fc_o
);
  always_comb begin
    if (iack_i) fc_o = 3'b111;
    else        fc_o = {super_i, prog_i, ~prog_i};
  end
endmodule

// File: rtl/abm_lanes.sv
module abm_lanes
  import abm_pkg::*;
#(
  parameter int DW = 16
) (
  input  xfer_size_e        size_i,
  input  logic              addr0_i,
  input  logic              second_i,
  input  logic [2*DW-1:0]   wdata_i,
  input  logic [DW-1:0]     bus_rd_i,
  output logic              uds_en_o,
  output logic              lds_en_o,
  output logic [DW-1:0]     wr_word_o,
  output logic [DW-1:0]     rd_word_o
);
  localparam int HB = DW / 2;

  always_comb begin
    if (size_i == SZ_BYTE) begin
      uds_en_o  = ~addr0_i;
      lds_en_o  = addr0_i;
      wr_word_o = {2{wdata_i[HB-1:0]}};
      rd_word_o = addr0_i ? {{HB{1'b0}}, bus_rd_i[HB-1:0]}
                          : {{HB{1'b0}}, bus_rd_i[DW-1:HB]};
    end else begin
      uds_en_o  = 1'b1;
      lds_en_o  = 1'b1;
      // long: high half goes out first, at the lower address
      wr_word_o = (size_i == SZ_LONG && !second_i) ? wdata_i[2*DW-1:DW] : wdata_i[DW-1:0];
      rd_word_o = bus_rd_i;
    end
  end
endmodule

// File: rtl/abm_seq.sv
module abm_seq
  import abm_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   long_i,
  input  logic   dtack_ni,
  input  logic   berr_ni,
  output phase_e phase_o,
  output logic   second_o,
  output logic   fault_o,
  output logic   finish_o
);
  phase_e phase_q;
  logic   second_q, fault_q, more;

  assign more = long_i && !second_q && !fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      second_q <= 1'b0;
      fault_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q  <= PH_S0;
          second_q <= 1'b0;
          fault_q  <= 1'b0;
        end
        PH_S0:   phase_q <= PH_S1;
        PH_S1:   phase_q <= PH_S2;
        PH_S2:   phase_q <= PH_S3;
        PH_S3:   phase_q <= PH_WAIT;
        PH_WAIT: begin
          if (!berr_ni) begin
            fault_q <= 1'b1;
            phase_q <= PH_END;
          end else if (!dtack_ni) begin
            phase_q <= PH_LATCH;
          end
        end
        PH_LATCH: phase_q <= PH_END;
        PH_END: begin
          if (more) begin
            phase_q  <= PH_S0;
            second_q <= 1'b1;
          end else begin
            phase_q  <= PH_IDLE;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o  = phase_q;
  assign second_o = second_q;
  assign fault_o  = fault_q;
  assign finish_o = (phase_q == PH_END) && !more;

  assert_wait_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT && dtack_ni && berr_ni) |=> (phase_q == PH_WAIT));

  assert_berr_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_WAIT && !berr_ni) |=> (phase_q == PH_END && fault_q));
endmodule

// File: rtl/abus_master.sv
module abus_master
  import abm_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [1:0]      req_size_i,
  input  logic            req_write_i,
  input  logic            req_super_i,
  input  logic            req_prog_i,
  input  logic            req_iack_i,
  input  logic [2*DW-1:0] req_wdata_i,
  output logic            rsp_done_o,
  output logic            rsp_err_o,
  output logic [2*DW-1:0] rsp_rdata_o,
  output logic [AW-1:1]   bus_addr_o,
  output logic            bus_as_no,
  output logic            bus_uds_no,
  output logic            bus_lds_no,
  output logic            bus_rw_o,
  output logic [2:0]      bus_fc_o,
  output logic [DW-1:0]   bus_data_o,
  output logic            bus_data_oe_o,
  input  logic [DW-1:0]   bus_data_i,
  input  logic            bus_dtack_ni,
  input  logic            bus_berr_ni
);
  localparam int LW = 2 * DW;

  phase_e     phase;
  logic       second, fault, finish;
  logic [AW-1:0] addr_q;
  xfer_size_e size_q, req_size;
  logic       write_q;
  logic [2:0] fc_q, fc_req;
  logic [LW-1:0] wdata_q, rdata_q;
  logic       done_q, err_q;
  logic       idle, misalign, start, reject;
  logic       in_cyc, addr_v, as_act, strb_act;
  logic       uds_en, lds_en;
  logic [DW-1:0] wr_word, rd_word;

  assign req_size = xfer_size_e'(req_size_i);
  assign idle     = (phase == PH_IDLE);
  assign misalign = (req_size != SZ_BYTE) && req_addr_i[0];
  assign start    = req_valid_i && idle && !misalign;
  assign reject   = req_valid_i && idle && misalign;

  abm_fc_enc u_fc (
    .super_i (req_super_i),
    .prog_i  (req_prog_i),
    .iack_i  (req_iack_i),
    .fc_o    (fc_req)
  );

  abm_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .long_i   (size_q == SZ_LONG),
    .dtack_ni (bus_dtack_ni),
    .berr_ni  (bus_berr_ni),
    .phase_o  (phase),
    .second_o (second),
    .fault_o  (fault),
    .finish_o (finish)
  );

  abm_lanes #(.DW(DW)) u_lanes (
    .size_i    (size_q),
    .addr0_i   (addr_q[0]),
    .second_i  (second),
    .wdata_i   (wdata_q),
    .bus_rd_i  (bus_data_i),
    .uds_en_o  (uds_en),
    .lds_en_o  (lds_en),
    .wr_word_o (wr_word),
    .rd_word_o (rd_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      size_q  <= SZ_BYTE;
      write_q <= 1'b0;
      fc_q    <= 3'b000;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= finish || reject;
      err_q  <= (finish && fault) || reject;
      if (start) begin
        addr_q  <= req_addr_i;
        size_q  <= req_size;
        write_q <= req_write_i;
        fc_q    <= fc_req;
        wdata_q <= req_wdata_i;
        rdata_q <= '0;
      end else if (phase == PH_LATCH && !write_q) begin
        rdata_q <= {rdata_q[DW-1:0], rd_word};
      end
    end
  end

  always_comb begin
    in_cyc   = phase inside {PH_S0, PH_S1, PH_S2, PH_S3, PH_WAIT, PH_LATCH};
    addr_v   = phase inside {PH_S1, PH_S2, PH_S3, PH_WAIT, PH_LATCH};
    as_act   = phase inside {PH_S2, PH_S3, PH_WAIT, PH_LATCH};
    // writes drop the strobes one phase after data is on the bus
    strb_act = write_q ? (phase inside {PH_S3, PH_WAIT, PH_LATCH}) : as_act;
  end

  assign bus_addr_o    = addr_v ? (addr_q[AW-1:1] + {{(AW-2){1'b0}}, second}) : '0;
  assign bus_as_no     = ~as_act;
  assign bus_uds_no    = ~(strb_act && uds_en);
  assign bus_lds_no    = ~(strb_act && lds_en);
  assign bus_rw_o      = ~(write_q && in_cyc);
  assign bus_fc_o      = in_cyc ? fc_q : 3'b000;
  assign bus_data_oe_o = write_q && as_act;
  assign bus_data_o    = bus_data_oe_o ? wr_word : '0;
  assign rsp_done_o    = done_q;
  assign rsp_err_o     = err_q;
  assign rsp_rdata_o   = err_q ? '0 : rdata_q;

  logic strb_any;
  assign strb_any = !bus_uds_no || !bus_lds_no;

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> (bus_as_no && bus_rw_o && !bus_data_oe_o && !strb_any));

  assert_strb_under_as_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strb_any |-> !bus_as_no);

  assert_fc_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_as_no |-> (bus_fc_o inside {3'b001, 3'b010, 3'b101, 3'b110, 3'b111}));

  assert_data_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_rw_o && $rose(strb_any)) |-> $past(bus_data_oe_o));

  assert_reject_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject |=> (bus_as_no && rsp_done_o && rsp_err_o));
endmodule

// File: tb/abus_master_bench.sv
`timescale 1ns/1ps
module abus_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0, req_super = 1'b0, req_prog = 1'b0, req_iack = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done, rsp_err;
  logic [31:0] rsp_rdata;
  logic [23:1] bus_addr;
  logic        bus_as_n, bus_uds_n, bus_lds_n, bus_rw, bus_oe;
  logic [2:0]  bus_fc;
  logic [15:0] bus_dout, bus_din;
  logic        bus_dtack_n, bus_berr_n;

  abus_master u_abus_master (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_write_i(req_write), .req_super_i(req_super), .req_prog_i(req_prog),
    .req_iack_i(req_iack), .req_wdata_i(req_wdata),
    .rsp_done_o(rsp_done), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
    .bus_addr_o(bus_addr), .bus_as_no(bus_as_n), .bus_uds_no(bus_uds_n),
    .bus_lds_no(bus_lds_n), .bus_rw_o(bus_rw), .bus_fc_o(bus_fc),
    .bus_data_o(bus_dout), .bus_data_oe_o(bus_oe), .bus_data_i(bus_din),
    .bus_dtack_ni(bus_dtack_n), .bus_berr_ni(bus_berr_n)
  );

  // slave model
  logic [7:0] mem [0:255];
  int  as_cnt = 0;
  int  wait_cfg = 0;
  bit  berr_mode = 1'b0;
  int  cyc = 0;

  assign bus_din     = {mem[{bus_addr[7:1], 1'b0}], mem[{bus_addr[7:1], 1'b1}]};
  assign bus_dtack_n = !(!bus_as_n && (!bus_uds_n || !bus_lds_n) && !berr_mode && as_cnt >= 2 + wait_cfg);
  assign bus_berr_n  = !(!bus_as_n && berr_mode && as_cnt >= 2);

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    as_cnt <= bus_as_n ? 0 : as_cnt + 1;
    if (!bus_dtack_n && !bus_rw && bus_oe) begin
      if (!bus_uds_n) mem[{bus_addr[7:1], 1'b0}] <= bus_dout[15:8];
      if (!bus_lds_n) mem[{bus_addr[7:1], 1'b1}] <= bus_dout[7:0];
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] rdata; logic err; int falls; int lat;
    logic [2:0] fc; logic [22:0] waddr; int start; string req;
  } exp_t;
  exp_t sb_q[$];

  // monitor: observes bus cycles and completions
  int falls = 0;
  logic [2:0]  seen_fc = '0;
  logic [22:0] seen_addr = '0;
  bit as_was_high = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!bus_as_n && as_was_high) begin
        if (falls == 0) begin seen_fc = bus_fc; seen_addr = bus_addr; end
        falls++;
      end
      as_was_high = bus_as_n;
      if (rsp_done) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R9", "unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(rsp_rdata == e.rdata, e.req, "rdata", rsp_rdata, e.rdata);
          chk(rsp_err == e.err, e.req, "err", {31'd0, rsp_err}, {31'd0, e.err});
          chk(falls == e.falls, e.req, "bus cycles", falls, e.falls);
          chk(cyc - e.start == e.lat, e.req, "latency", cyc - e.start, e.lat);
          if (e.falls > 0) begin
            chk(seen_fc == e.fc, e.req, "fc", {29'd0, seen_fc}, {29'd0, e.fc});
            chk(seen_addr == e.waddr, e.req, "addr", {9'd0, seen_addr}, {9'd0, e.waddr});
          end
        end
        falls = 0;
      end
    end
  end

  task automatic drive(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                       input logic sup, input logic prog, input logic iack, input logic [31:0] wd);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr;
    req_super = sup; req_prog = prog; req_iack = iack; req_wdata = wd;
  endtask

  task automatic issue(input logic [23:0] a, input logic [1:0] sz, input logic wr,
                       input logic sup, input logic prog, input logic iack, input logic [31:0] wd,
                       input logic [31:0] er, input logic ee, input int ef, input int el,
                       input logic [2:0] efc, input string req);
    exp_t e;
    @(negedge clk);
    drive(a, sz, wr, sup, prog, iack, wd);
    e.rdata = er; e.err = ee; e.falls = ef; e.lat = el; e.fc = efc;
    e.waddr = a[23:1]; e.start = cyc; e.req = req;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    wait (sb_q.size() == 0);
    @(negedge clk);
  endtask

  task automatic chk_mem(input logic [7:0] a, input logic [7:0] exp, input string req);
    chk(mem[a] == exp, req, $sformatf("mem[%h]", a), {24'd0, mem[a]}, {24'd0, exp});
  endtask

  bit finished = 1'b0;
  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bus_as_n && bus_uds_n && bus_lds_n, "R1", "strobes idle", {29'd0, bus_as_n, bus_uds_n, bus_lds_n}, 32'd7);
    chk(bus_rw && !bus_oe, "R1", "rw/oe idle", {30'd0, bus_rw, bus_oe}, 32'd2);
    chk(!rsp_done, "R1", "done low", {31'd0, rsp_done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(bus_as_n && bus_rw && !bus_oe && !rsp_done, "R1", "idle after reset",
        {28'd0, bus_as_n, bus_rw, bus_oe, rsp_done}, 32'hC);

    // R6 word write, big-endian; R3 supervisor data fc 101
    issue(24'h000010, 2'd1, 1, 1, 0, 0, 32'h0000_1234, 32'h0, 0, 1, 8, 3'b101, "R6");
    chk_mem(8'h10, 8'h12, "R6");
    chk_mem(8'h11, 8'h34, "R6");
    // R2/R5 byte writes hit only their lane; R3 user data fc 001
    issue(24'h000021, 2'd0, 1, 0, 0, 0, 32'h0000_00AB, 32'h0, 0, 1, 8, 3'b001, "R5");
    chk_mem(8'h21, 8'hAB, "R5");
    chk_mem(8'h20, 8'h7A, "R2");
    issue(24'h000022, 2'd0, 1, 0, 0, 0, 32'h0000_00CD, 32'h0, 0, 1, 8, 3'b001, "R2");
    chk_mem(8'h22, 8'hCD, "R2");
    chk_mem(8'h23, 8'h79, "R5");
    // R6 long write at a high address (also R2 pin address), user program fc 010
    issue(24'hABCD40, 2'd2, 1, 0, 1, 0, 32'h1234_5678, 32'h0, 0, 2, 15, 3'b010, "R6");
    chk_mem(8'h40, 8'h12, "R6");
    chk_mem(8'h41, 8'h34, "R6");
    chk_mem(8'h42, 8'h56, "R6");
    chk_mem(8'h43, 8'h78, "R6");
    // R6 long read, supervisor program fc 110
    issue(24'hABCD40, 2'd2, 0, 1, 1, 0, 32'h0, 32'h1234_5678, 0, 2, 15, 3'b110, "R6");
    // R10 byte reads from each lane
    issue(24'h000041, 2'd0, 0, 1, 0, 0, 32'h0, 32'h0000_0034, 0, 1, 8, 3'b101, "R10");
    issue(24'h000040, 2'd0, 0, 1, 0, 0, 32'h0, 32'h0000_0012, 0, 1, 8, 3'b101, "R10");
    // R4 wait states
    wait_cfg = 3;
    issue(24'h000042, 2'd1, 0, 1, 0, 0, 32'h0, 32'h0000_5678, 0, 1, 11, 3'b101, "R4");
    wait_cfg = 2;
    issue(24'h000010, 2'd2, 0, 1, 0, 0, 32'h0, 32'h1234_4849, 0, 2, 19, 3'b101, "R4");
    wait_cfg = 0;
    // R3 interrupt acknowledge fc 111
    issue(24'h000031, 2'd0, 0, 0, 1, 1, 32'h0, 32'h0000_006B, 0, 1, 8, 3'b111, "R3");
    // R7 odd-address word / long rejected
    issue(24'h000011, 2'd1, 0, 1, 0, 0, 32'h0, 32'h0, 1, 0, 1, 3'b000, "R7");
    issue(24'h000043, 2'd2, 1, 1, 0, 0, 32'hDEAD_BEEF, 32'h0, 1, 0, 1, 3'b000, "R7");
    chk_mem(8'h43, 8'h78, "R7");
    chk_mem(8'h44, 8'h1E, "R7");
    // R8 bus error
    berr_mode = 1'b1;
    issue(24'h000010, 2'd1, 0, 1, 0, 0, 32'h0, 32'h0, 1, 1, 7, 3'b101, "R8");
    issue(24'h000050, 2'd2, 1, 0, 0, 0, 32'h1122_3344, 32'h0, 1, 1, 7, 3'b001, "R8");
    chk_mem(8'h50, 8'h0A, "R8");
    chk_mem(8'h52, 8'h08, "R8");
    berr_mode = 1'b0;
    // R9 request during a transfer is ignored
    begin
      exp_t e;
      @(negedge clk);
      drive(24'h000060, 2'd0, 1, 0, 0, 0, 32'h77);
      e.rdata = 0; e.err = 0; e.falls = 1; e.lat = 8; e.fc = 3'b001;
      e.waddr = 23'h30; e.start = cyc; e.req = "R9";
      sb_q.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      drive(24'h000070, 2'd0, 1, 0, 0, 0, 32'h99);
      @(negedge clk);
      req_valid = 1'b0;
      wait (sb_q.size() == 0);
      repeat (20) @(negedge clk);
      chk_mem(8'h60, 8'h77, "R9");
      chk_mem(8'h70, 8'h2A, "R9");
    end
    finish_run();
  end
endmodule